// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synchronous static RAM. Reads and writes can follow each other on every clock with no idle cycle between them. Address, the three chip selects, write enable, byte enables and the advance/load control are all registered on the rising clock edge.

Write data is not taken with the command. It is taken later, after the same number of edges that read data needs to reach the output. This lets a bus master interleave reads and writes freely on a shared data path. A static mode input selects one of two pipelines:
- A two-stage pipeline, where write data arrives two edges after the command.
- A one-stage flow-through pipeline, where write data arrives one edge after the command.

The data bus is split into an input bus and an output bus. An enable flag marks when the output would be driving a shared bus. When the flag is low, the output bus is forced to zero. Clock enable freezes all internal state. An asynchronous output enable and a sleep input force the output off at any time. Bursts of four words step the low two address bits in linear order. In two-stage mode, a read issued right after a write to the same word returns the pending write data, merged byte by byte.

Top module: `turnless_sram`

## Requirements
- R1: A new access starts only at an enabled edge with `adv_ld` low and all three selects active (`sel1_n` low, `sel2` high, `sel3_n` low). Otherwise the cycle is a deselect and produces no output.
- R2: In two-stage mode (`flow_mode`=0), a read registered at edge n drives `dout_en` high with the word on `dout` from just after edge n+1 until edge n+2.
- R3: In two-stage mode, the data for a write registered at edge n is taken from `din` at enabled edge n+2.
- R4: In flow-through mode (`flow_mode`=1), read data is driven right after the command edge n. Write data is taken from `din` at enabled edge n+1.
- R5: `bw_n[i]` is active low and selects bits `din[9i+8:9i]`. A write with all four byte enables high changes nothing.
- R6: While `cke_n` is high, no state changes. A stalled two-stage read keeps driving the same word, and a stalled write keeps `dout_en` low.
- R7: `oe_n` high forces `dout_en` low with no clock edge. `dout_en` is low in every write data cycle. A read issued with `oe_n` high has no effect on the stored data.
- R8: `sleep` high forces `dout_en` low with no clock edge.
- R9: An access with `adv_ld` high continues the previous access type. Its address has the low two bits incremented modulo 4 and the upper bits kept. A continue after a deselect stays deselected.
- R10: After reset, `dout_en` is low and the block is deselected.
- R11: In two-stage mode, a read registered one edge after a write to the same address returns the write's `din` bytes where that write's byte enables were active, and the stored bytes elsewhere.
- R12: Whenever `dout_en` is low, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_n | input | 1 | Clock enable, active low; high freezes all state |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | High continues the burst, low loads a new address |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | 4 | Byte enables, active low, one per 9-bit byte |
| addr | input | 8 | Word address |
| din | input | 36 | Late write data |
| flow_mode | input | 1 | Static: 1 selects flow-through, 0 selects two-stage |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous output shutdown, active high |
| dout | output | 36 | Read data, zero when not driving |
| dout_en | output | 1 | High where a tri-state bus would be driven |

## Verification
The assertions assume that `flow_mode` is static while the block is running. If the mode changes, the second stage and the output register can hold a command left from the other mode. The stimulus therefore changes the mode only after deselect cycles, or across a fresh reset.

The properties also assume that `cke_n` is a clean level sampled at the edge. Under that assumption, the second stage and the output register always advance together. The stimulus reads a word only after a full write to it, so no read exposes an uninitialised word.

// File: rtl/tls_pkg.sv
package tls_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/tls_cmd_stage.sv
module tls_cmd_stage
  import tls_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              adv_ld,
  input  logic              sel_ok,
  input  logic              we_n,
  input  logic [NBYTE-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              s1_type,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [NBYTE-1:0]  s1_mask
);
  // Linear burst step: only the low bits advance, and they wrap.
  function automatic logic [ADDR_W-1:0] burst_next(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    r[BURST_W-1:0] = a[BURST_W-1:0] + {{(BURST_W-1){1'b0}}, 1'b1};
    return r;
  endfunction

  logic load_cmd;
  logic cont_cmd;
  acc_e new_type;

  assign load_cmd = step_en && !adv_ld;
  assign cont_cmd = step_en && adv_ld;
  assign new_type = !sel_ok ? ACC_IDLE : (we_n ? ACC_READ : ACC_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_type <= ACC_IDLE;
      s1_addr <= '0;
      s1_mask <= '0;
    end else if (load_cmd) begin
      s1_type <= new_type;
      s1_addr <= addr;
      s1_mask <= ~bw_n;
    end else if (cont_cmd) begin
      s1_addr <= burst_next(s1_addr);
      s1_mask <= ~bw_n;
    end
  end

  AST_SELECT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cmd && !sel_ok) |=> (s1_type == ACC_IDLE)); // R1
  AST_DESELECT_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_cmd && s1_type == ACC_IDLE) |=> (s1_type == ACC_IDLE)); // R9
  AST_BURST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cont_cmd |=> (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W]))); // R9
endmodule

// File: rtl/tls_array.sv
module tls_array #(
  parameter int ADDR_W = 8,
  parameter int NBYTE  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [NBYTE-1:0]        wr_mask,
  input  logic [NBYTE*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [NBYTE*BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[b]) lane_mem[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
    end

    assign rd_data[b*BYTE_W +: BYTE_W] = lane_mem[rd_addr];
  end
endmodule

// File: rtl/tls_out_stage.sv
module tls_out_stage #(
  parameter int NBYTE  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_en,
  input  logic                    flow_mode,
  input  logic                    s1_rd,
  input  logic [NBYTE-1:0]        fwd_mask,
  input  logic [NBYTE*BYTE_W-1:0] arr_data,
  input  logic [NBYTE*BYTE_W-1:0] din,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [NBYTE*BYTE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = NBYTE * BYTE_W;

  // Overlay the lanes of 'newer' selected by 'take' onto 'base'.
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] base,
                                                   input logic [DATA_W-1:0] newer,
                                                   input logic [NBYTE-1:0]  take);
    logic [DATA_W-1:0] r;
    r = base;
    for (int b = 0; b < NBYTE; b++)
      if (take[b]) r[b*BYTE_W +: BYTE_W] = newer[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic              q_valid;
  logic [DATA_W-1:0] q_data;
  logic              rd_live;
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else if (step_en) begin
      q_valid <= s1_rd;
      q_data  <= lane_merge(arr_data, din, fwd_mask);
    end
  end

  assign rd_live = flow_mode ? s1_rd : q_valid;
  assign rd_word = flow_mode ? arr_data : q_data;
  assign dout_en = rd_live && !oe_n && !sleep;
  assign dout    = dout_en ? rd_word : '0;

  AST_PIPE_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !flow_mode && s1_rd) |=> q_valid); // R2
  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(q_data) && $stable(q_valid))); // R6
endmodule

// File: rtl/turnless_sram.sv
module turnless_sram
  import tls_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTE  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    adv_ld,
  input  logic                    we_n,
  input  logic [NBYTE-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NBYTE*BYTE_W-1:0] din,
  input  logic                    flow_mode,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [NBYTE*BYTE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = NBYTE * BYTE_W;

  logic              step_en;
  logic              sel_ok;
  acc_e              s1_type;
  logic [ADDR_W-1:0] s1_addr;
  logic [NBYTE-1:0]  s1_mask;
  acc_e              s2_type;
  logic [ADDR_W-1:0] s2_addr;
  logic [NBYTE-1:0]  s2_mask;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [NBYTE-1:0]  commit_mask;
  logic              fwd_hit;
  logic [NBYTE-1:0]  fwd_mask;
  logic [DATA_W-1:0] arr_data;

  assign step_en = !cke_n;
  assign sel_ok  = !sel1_n && sel2 && !sel3_n;

  tls_cmd_stage #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) cmd_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .adv_ld(adv_ld), .sel_ok(sel_ok),
    .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .s1_type(s1_type), .s1_addr(s1_addr), .s1_mask(s1_mask)
  );

  // Second stage: delays a write by one more edge in two-stage mode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_type <= ACC_IDLE;
      s2_addr <= '0;
      s2_mask <= '0;
    end else if (step_en) begin
      s2_type <= s1_type;
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
    end
  end

  assign commit_en   = step_en && (flow_mode ? (s1_type == ACC_WRITE) : (s2_type == ACC_WRITE));
  assign commit_addr = flow_mode ? s1_addr : s2_addr;
  assign commit_mask = flow_mode ? s1_mask : s2_mask;

  assign fwd_hit  = !flow_mode && (s2_type == ACC_WRITE) && (s1_type == ACC_READ) && (s2_addr == s1_addr);
  assign fwd_mask = fwd_hit ? s2_mask : '0;

  tls_array #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) array_i (
    .clk(clk), .wr_en(commit_en), .wr_addr(commit_addr), .wr_mask(commit_mask),
    .wr_data(din), .rd_addr(s1_addr), .rd_data(arr_data)
  );

  tls_out_stage #(.NBYTE(NBYTE), .BYTE_W(BYTE_W)) out_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .flow_mode(flow_mode),
    .s1_rd(s1_type == ACC_READ), .fwd_mask(fwd_mask), .arr_data(arr_data), .din(din),
    .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  AST_WRITE_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((flow_mode ? s1_type : s2_type) == ACC_WRITE) |-> !dout_en); // R7
  AST_IDLE_ZERO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0)); // R12
endmodule

// File: tb/turnless_sram_tb_top.sv
module turnless_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  localparam logic [35:0] VA = 36'h9_A5A5_A5A5;
  localparam logic [35:0] VB = 36'h0_0000_0000;
  localparam logic [35:0] VC = 36'hF_FFFF_FFFF;
  localparam logic [35:0] VM = 36'h0_07FC_01FF; // lanes 0 and 2 of VC over VB
  localparam logic [35:0] D1 = 36'h1_1111_1111;
  localparam logic [35:0] D2 = 36'h2_2222_2222;
  localparam logic [35:0] VE = 36'h3_C3C3_C3C3;
  localparam logic [35:0] VF = 36'h4_4444_4444;

  typedef struct packed {
    logic        flow;
    logic        desel;
    logic        adv;
    logic        we_n;
    logic [3:0]  bw_n;
    logic [7:0]  addr;
    logic [35:0] din;
    logic        exp_en;
    logic [35:0] exp_q;
    logic [7:0]  req;
  } vec_t;

  // One row per enabled edge: inputs before the edge, outputs after it.
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,4'h0,8'h10,36'h0,1'b0,36'h0,8'd3},  // R3 write 0x10
    '{1'b0,1'b0,1'b0,1'b0,4'h0,8'h12,36'h0,1'b0,36'h0,8'd3},  // R3 write 0x12
    '{1'b0,1'b0,1'b0,1'b1,4'hF,8'h10,VA,   1'b0,36'h0,8'd2},  // R2 read 0x10, data for 0x10
    '{1'b0,1'b0,1'b0,1'b1,4'hF,8'h12,VB,   1'b1,VA,   8'd3},  // R3 read 0x12
    '{1'b0,1'b0,1'b0,1'b0,4'hA,8'h12,36'h0,1'b1,VB,   8'd2},  // R2 partial write 0x12
    '{1'b0,1'b0,1'b0,1'b1,4'hF,8'h12,36'h0,1'b0,36'h0,8'd7},  // R7 read behind write
    '{1'b0,1'b1,1'b0,1'b1,4'hF,8'h00,VC,   1'b1,VM,   8'd11}, // R11 forwarded lanes
    '{1'b0,1'b1,1'b0,1'b1,4'hF,8'h00,36'h0,1'b0,36'h0,8'd1},  // R1 deselect
    '{1'b0,1'b0,1'b0,1'b0,4'h0,8'h23,36'h0,1'b0,36'h0,8'd9},  // R9 burst write start
    '{1'b0,1'b0,1'b1,1'b0,4'h0,8'h00,36'h0,1'b0,36'h0,8'd9},  // R9 continue to 0x20
    '{1'b0,1'b0,1'b0,1'b1,4'hF,8'h23,D1,   1'b0,36'h0,8'd9},  // R9 read 0x23
    '{1'b0,1'b0,1'b1,1'b1,4'hF,8'h00,D2,   1'b1,D1,   8'd9},  // R9 continue read 0x20
    '{1'b0,1'b1,1'b0,1'b1,4'hF,8'h00,36'h0,1'b1,D2,   8'd9},  // R9 wrapped address
    '{1'b0,1'b0,1'b1,1'b1,4'hF,8'h00,36'h0,1'b0,36'h0,8'd9},  // R9 continue after deselect
    '{1'b0,1'b1,1'b0,1'b1,4'hF,8'h00,36'h0,1'b0,36'h0,8'd9},  // R9 still nothing driven
    '{1'b1,1'b0,1'b0,1'b0,4'h0,8'h40,36'h0,1'b0,36'h0,8'd4},  // R4 flow write 0x40
    '{1'b1,1'b0,1'b0,1'b1,4'hF,8'h40,VE,   1'b1,VE,   8'd4},  // R4 flow read right away
    '{1'b1,1'b0,1'b0,1'b0,4'hE,8'h41,36'h0,1'b0,36'h0,8'd7},  // R7 flow write phase quiet
    '{1'b1,1'b0,1'b0,1'b1,4'hF,8'h40,VF,   1'b1,VE,   8'd4},  // R4 read again
    '{1'b1,1'b1,1'b0,1'b1,4'hF,8'h00,36'h0,1'b0,36'h0,8'd1}   // R1 deselect
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke_n, sel1_n, sel2, sel3_n, adv_ld, we_n;
  logic [3:0]  bw_n;
  logic [7:0]  addr;
  logic [35:0] din;
  logic        flow_mode, oe_n, sleep;
  logic [35:0] dout;
  logic        dout_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  turnless_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .addr(addr), .din(din),
    .flow_mode(flow_mode), .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp_en, input logic [35:0] exp_q);
    n_chk++;
    if (dout_en !== exp_en || dout !== exp_q) begin
      n_fail++;
      $display("FAIL %s: got en=%0b dout=%h, expected en=%0b dout=%h",
               req, dout_en, dout, exp_en, exp_q);
    end
  endtask

  task automatic cmd(input logic desel, input logic adv, input logic wn,
                     input logic [3:0] bwn, input logic [7:0] a, input logic [35:0] d);
    sel1_n = desel; adv_ld = adv; we_n = wn; bw_n = bwn; addr = a; din = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cke_n = 1'b0; sel1_n = 1'b1; sel2 = 1'b1; sel3_n = 1'b0; adv_ld = 1'b0;
    we_n = 1'b1; bw_n = 4'hF; addr = '0; din = '0; flow_mode = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got no end, expected end of run");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R10 reset state, R12 zero bus", 1'b0, 36'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      flow_mode = VECS[i].flow;
      cmd(VECS[i].desel, VECS[i].adv, VECS[i].we_n, VECS[i].bw_n, VECS[i].addr, VECS[i].din);
      step();
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp_en, VECS[i].exp_q);
    end

    // Directed: fresh reset, two-stage mode
    do_reset();
    chk("R10 after second reset", 1'b0, 36'h0);
    cmd(0, 0, 0, 4'h0, 8'h50, 36'h0);          step();
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h0);          step();
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h5_5555_5555); step();
    cmd(0, 0, 1, 4'hF, 8'h50, 36'h0);          step();
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h0);          step();
    chk("R2 read of 0x50", 1'b1, 36'h5_5555_5555);

    // R6 stalled read keeps driving while other commands are presented
    cke_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cmd(0, 0, 0, 4'h0, 8'h60 + 8'(k), 36'hA_AAAA_AAAA);
      step();
      chk("R6 stalled read holds", 1'b1, 36'h5_5555_5555);
    end
    cke_n = 1'b0;
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h0); step();
    chk("R6 resumes after stall", 1'b0, 36'h0);

    // R6 stalled write: data edge counts only enabled edges
    cmd(0, 0, 0, 4'h0, 8'h51, 36'h0); step();
    cke_n = 1'b1;
    cmd(1, 0, 1, 4'hF, 8'h00, 36'hB_0000_000B); step();
    chk("R6 stalled write stays quiet", 1'b0, 36'h0);
    step();
    cke_n = 1'b0;
    cmd(1, 0, 1, 4'hF, 8'h00, 36'hC_0000_000C); step();
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h6_789A_BCDE); step();
    cmd(0, 0, 1, 4'hF, 8'h51, 36'h0);          step();
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h0);          step();
    chk("R3 R6 data taken at second enabled edge", 1'b1, 36'h6_789A_BCDE);

    // R7 asynchronous output enable, R8 sleep
    oe_n = 1'b1; #1;
    chk("R7 oe_n high turns output off", 1'b0, 36'h0);
    oe_n = 1'b0; #1;
    chk("R7 oe_n low restores output", 1'b1, 36'h6_789A_BCDE);
    sleep = 1'b1; #1;
    chk("R8 sleep turns output off", 1'b0, 36'h0);
    sleep = 1'b0; #1;

    // R7 dummy read with oe_n high
    oe_n = 1'b1;
    cmd(0, 0, 1, 4'hF, 8'h50, 36'h0); step();
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h0); step();
    chk("R7 dummy read stays off", 1'b0, 36'h0);
    oe_n = 1'b0;
    cmd(0, 0, 1, 4'hF, 8'h50, 36'h0); step();
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h0); step();
    chk("R7 data intact after dummy read", 1'b1, 36'h5_5555_5555);

    // R1 each select alone blocks a read
    sel2 = 1'b0;
    cmd(0, 0, 1, 4'hF, 8'h51, 36'h0); step();
    sel2 = 1'b1;
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h0); step();
    chk("R1 sel2 low blocks read", 1'b0, 36'h0);
    sel3_n = 1'b1;
    cmd(0, 0, 1, 4'hF, 8'h51, 36'h0); step();
    sel3_n = 1'b0;
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h0); step();
    chk("R1 sel3_n high blocks read", 1'b0, 36'h0);

    // R5 write with no byte enabled changes nothing
    cmd(0, 0, 0, 4'hF, 8'h51, 36'h0); step();
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h0); step();
    cmd(1, 0, 1, 4'hF, 8'h00, 36'hF_FFFF_FFFF); step();
    cmd(0, 0, 1, 4'hF, 8'h51, 36'h0); step();
    cmd(1, 0, 1, 4'hF, 8'h00, 36'h0); step();
    chk("R5 no-op write left word", 1'b1, 36'h6_789A_BCDE);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule